// File: doc/BRIEF.md
# Link Ingress Buffer with Idle Filtering

This block sits behind a deserialising transceiver and accepts one 32-bit word per cycle of the link's recovered clock, together with one K-character flag per byte and an indication that the link has locked its word boundary. Idle fill words are dropped at the entrance; every other word, with its four K flags attached, is placed in a 1024-entry buffer whose write side runs on the link clock and whose read side runs on the system clock. The two pointers cross between domains in Gray code through two-flop synchronisers.

The read side drains by itself: whenever the buffer is not empty, the head word is presented and consumed on the next system clock edge. Downstream logic takes a word on every system clock cycle in which the empty flag is low. On the link side, an occupancy level of 70% of the depth raises a half-full flag, and that flag is driven out unchanged as the hold (backpressure) line to the upstream sender. Each clock domain has its own active-low reset, asserted asynchronously and released through a two-flop synchroniser.

Top module: `lib_link_ingress`

## Requirements
- R1: A word whose data is 0xBCBC1C1C while all four K flags are set (flag value 4'hF) is never stored.
- R2: A word matching only one half of the idle test (the idle data with any K flag clear, or other data with all K flags set) is stored like any other word.
- R3: While the aligned input is low, no word is stored, idle or not.
- R4: Stored words leave in arrival order; the output word holds the K flags in bits 35:32 and the data in bits 31:0.
- R5: After reset the empty flag is high; a word is presented while empty is low and is consumed on the next system clock edge, so the buffer drains without any request, and empty returns high once it is drained.
- R6: The half-full flag is low with 716 words held and goes high once 717 words are held, with the occupancy taken from the write pointer and the synchronised read pointer.
- R7: The hold output carries the same value as the half-full flag in every link cycle.
- R8: The buffer holds at most 1024 words; words arriving while it is full are discarded and those already held are kept intact.
- R9: Once the reader has drained the buffer, the half-full flag and the hold line return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lnk_clk | input | 1 | Recovered link clock, write side |
| lnk_rst_n | input | 1 | Active-low reset of the link domain |
| lnk_data | input | 32 | Parallel word from the deserialiser |
| lnk_kflag | input | 4 | K-character flag for each byte of the word |
| lnk_aligned | input | 1 | High once the link has locked word alignment |
| lnk_half | output | 1 | Occupancy has reached 70% of depth |
| lnk_hold | output | 1 | Backpressure to the upstream sender |
| sys_clk | input | 1 | System clock, read side |
| sys_rst_n | input | 1 | Active-low reset of the system domain |
| sys_data | output | 36 | Head word: K flags in 35:32, data in 31:0 |
| sys_empty | output | 1 | No word available; low means a word is consumed this cycle |

## Verification
The stimulus mixes exact idle words with near misses that differ in a single K flag or a single data bit, so a filter that tests only the data pattern or only the K mask drops words it should keep, and words sent while alignment is low catch a filter that ignores the aligned input. The threshold is probed at exactly 716 and 717 held words with the reader kept in reset, so an off-by-one or a 50% threshold shows up at the port. Overfilling past 1024 then draining shows whether a full buffer wraps over its oldest words, and draining to empty shows whether hold clears again.

// File: rtl/lib_pkg.sv
package lib_pkg;
  localparam int unsigned LNK_DW = 32;
  localparam int unsigned LNK_KW = 4;
  localparam logic [LNK_DW-1:0] IDLE_DATA = 32'hBCBC_1C1C;
  localparam logic [LNK_KW-1:0] IDLE_KMASK = 4'hF;

  typedef struct packed {
    logic [LNK_KW-1:0] kflag;
    logic [LNK_DW-1:0] data;
  } lnk_word_t;

  localparam int unsigned WORD_W = $bits(lnk_word_t);
endpackage

// File: rtl/lib_idle_filter.sv
module lib_idle_filter
  import lib_pkg::*;
(
  input  logic [LNK_DW-1:0] data,
  input  logic [LNK_KW-1:0] kflag,
  input  logic              aligned,
  output logic              keep
);
  logic is_idle;

  always_comb begin
    is_idle = (data == IDLE_DATA) && (kflag == IDLE_KMASK);
    keep    = aligned && !is_idle;
  end
endmodule

// File: rtl/lib_ptr_sync.sv
module lib_ptr_sync #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/lib_fifo_wr_ctl.sv
module lib_fifo_wr_ctl #(
  parameter int unsigned AW       = 10,
  parameter int unsigned HF_LEVEL = 717
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW:0]   wbin,
  output logic [AW-1:0] waddr,
  output logic          wr_en,
  output logic [AW:0]   occ,
  output logic          half
);
  logic [AW:0] rbin_sync;
  logic [AW:0] wbin_d;
  logic        full;

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    rbin_sync = g2b(rgray_sync);
    occ       = wbin - rbin_sync;
    full      = occ[AW];
    half      = occ >= (AW+1)'(HF_LEVEL);
    wr_en     = push_req && !full;
    wbin_d    = wbin + {{AW{1'b0}}, wr_en};
    waddr     = wbin[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_d;
      wgray <= wbin_d ^ (wbin_d >> 1);
    end
  end
endmodule

// File: rtl/lib_fifo_rd_ctl.sv
module lib_fifo_rd_ctl #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   wgray_sync,
  output logic [AW:0]   rgray,
  output logic [AW:0]   rbin,
  output logic [AW-1:0] raddr,
  output logic          empty,
  output logic          pop
);
  logic [AW:0] rbin_d;

  always_comb begin
    empty  = (rgray == wgray_sync);
    pop    = !empty;
    rbin_d = rbin + {{AW{1'b0}}, pop};
    raddr  = rbin[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_d;
      rgray <= rbin_d ^ (rbin_d >> 1);
    end
  end
endmodule

// File: rtl/lib_link_ingress.sv
module lib_link_ingress
  import lib_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned HF_PCT = 70
) (
  input  logic                lnk_clk,
  input  logic                lnk_rst_n,
  input  logic [LNK_DW-1:0]   lnk_data,
  input  logic [LNK_KW-1:0]   lnk_kflag,
  input  logic                lnk_aligned,
  output logic                lnk_half,
  output logic                lnk_hold,
  input  logic                sys_clk,
  input  logic                sys_rst_n,
  output logic [WORD_W-1:0]   sys_data,
  output logic                sys_empty
);
  localparam int unsigned AW       = $clog2(DEPTH);
  localparam int unsigned HF_LEVEL = (DEPTH * HF_PCT + 99) / 100;

  logic [1:0]  lnk_rst_pipe, sys_rst_pipe;
  logic        lnk_rst_sync, sys_rst_sync;
  logic        keep, wr_en, r_pop;
  logic [AW:0] w_gray, w_bin, w_occ, w_gray_s;
  logic [AW:0] r_gray, r_bin, r_gray_s;
  logic [AW-1:0] waddr, raddr;
  lnk_word_t   in_word;
  lnk_word_t   mem [DEPTH];

  always_ff @(posedge lnk_clk or negedge lnk_rst_n) begin
    if (!lnk_rst_n) lnk_rst_pipe <= 2'b00;
    else            lnk_rst_pipe <= {lnk_rst_pipe[0], 1'b1};
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) sys_rst_pipe <= 2'b00;
    else            sys_rst_pipe <= {sys_rst_pipe[0], 1'b1};
  end

  assign lnk_rst_sync = lnk_rst_pipe[1];
  assign sys_rst_sync = sys_rst_pipe[1];

  lib_idle_filter u_filt (
    .data(lnk_data), .kflag(lnk_kflag), .aligned(lnk_aligned), .keep(keep)
  );

  lib_fifo_wr_ctl #(.AW(AW), .HF_LEVEL(HF_LEVEL)) u_wr (
    .clk(lnk_clk), .rst_n(lnk_rst_sync), .push_req(keep), .rgray_sync(r_gray_s),
    .wgray(w_gray), .wbin(w_bin), .waddr(waddr), .wr_en(wr_en),
    .occ(w_occ), .half(lnk_half)
  );

  lib_ptr_sync #(.W(AW+1)) u_r2w (
    .clk(lnk_clk), .rst_n(lnk_rst_sync), .d(r_gray), .q(r_gray_s)
  );

  lib_ptr_sync #(.W(AW+1)) u_w2r (
    .clk(sys_clk), .rst_n(sys_rst_sync), .d(w_gray), .q(w_gray_s)
  );

  lib_fifo_rd_ctl #(.AW(AW)) u_rd (
    .clk(sys_clk), .rst_n(sys_rst_sync), .wgray_sync(w_gray_s),
    .rgray(r_gray), .rbin(r_bin), .raddr(raddr), .empty(sys_empty), .pop(r_pop)
  );

  always_comb begin
    in_word.kflag = lnk_kflag;
    in_word.data  = lnk_data;
  end

  always_ff @(posedge lnk_clk) begin
    if (wr_en) mem[waddr] <= in_word;
  end

  assign sys_data = mem[raddr];
  assign lnk_hold = lnk_half;
endmodule

// File: rtl/lib_link_ingress_chk.sv
module lib_link_ingress_chk #(
  parameter int unsigned AW       = 10,
  parameter int unsigned DEPTH    = 1024,
  parameter int unsigned HF_LEVEL = 717
) (
  input logic          lnk_clk,
  input logic          lnk_rst_n,
  input logic [31:0]   lnk_data,
  input logic [3:0]    lnk_kflag,
  input logic          lnk_aligned,
  input logic [AW:0]   w_bin,
  input logic [AW:0]   w_occ,
  input logic          lnk_half,
  input logic          sys_clk,
  input logic          sys_rst_n,
  input logic          sys_empty,
  input logic [AW:0]   r_bin
);
  // R1
  idle_not_stored_chk: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    (lnk_aligned && lnk_data == 32'hBCBC_1C1C && lnk_kflag == 4'hF) |=> $stable(w_bin));

  // R3
  unaligned_ignored_chk: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    !lnk_aligned |=> $stable(w_bin));

  // R8
  no_overflow_chk: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    w_occ <= (AW+1)'(DEPTH));

  // R6
  half_rise_level_chk: assert property (@(posedge lnk_clk) disable iff (!lnk_rst_n)
    $rose(lnk_half) |-> w_occ == (AW+1)'(HF_LEVEL));

  // R5
  empty_no_pop_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    sys_empty |=> $stable(r_bin));
endmodule

bind lib_link_ingress lib_link_ingress_chk #(
  .AW(AW), .DEPTH(DEPTH), .HF_LEVEL(HF_LEVEL)
) u_chk (
  .lnk_clk(lnk_clk), .lnk_rst_n(lnk_rst_sync), .lnk_data(lnk_data),
  .lnk_kflag(lnk_kflag), .lnk_aligned(lnk_aligned), .w_bin(w_bin),
  .w_occ(w_occ), .lnk_half(lnk_half), .sys_clk(sys_clk),
  .sys_rst_n(sys_rst_sync), .sys_empty(sys_empty), .r_bin(r_bin)
);

// File: tb/lib_link_ingress_tb.sv
module lib_link_ingress_tb;
  logic        lnk_clk = 1'b0;
  logic        sys_clk = 1'b0;
  logic        lnk_rst_n, sys_rst_n;
  logic [31:0] lnk_data = '0;
  logic [3:0]  lnk_kflag = '0;
  logic        lnk_aligned = 1'b0;
  logic        lnk_half, lnk_hold, sys_empty;
  logic [35:0] sys_data;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  int got_n  = 0;
  logic [35:0] got [2048];

  always #4 sys_clk = ~sys_clk;
  always #5 lnk_clk = ~lnk_clk;

  lib_link_ingress u_dut (
    .lnk_clk(lnk_clk), .lnk_rst_n(lnk_rst_n), .lnk_data(lnk_data),
    .lnk_kflag(lnk_kflag), .lnk_aligned(lnk_aligned), .lnk_half(lnk_half),
    .lnk_hold(lnk_hold), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .sys_data(sys_data), .sys_empty(sys_empty)
  );

  // {aligned, kflag, data, stored}
  localparam logic [37:0] VEC [12] = '{
    {1'b1, 4'hF, 32'hBCBC_1C1C, 1'b0},
    {1'b1, 4'h0, 32'h0000_0001, 1'b1},
    {1'b1, 4'hE, 32'hBCBC_1C1C, 1'b1},
    {1'b1, 4'hF, 32'hBCBC_1C1D, 1'b1},
    {1'b0, 4'h0, 32'h0000_0002, 1'b0},
    {1'b1, 4'hF, 32'hBCBC_1C1C, 1'b0},
    {1'b1, 4'h1, 32'hA5A5_5A5A, 1'b1},
    {1'b0, 4'hF, 32'hBCBC_1C1C, 1'b0},
    {1'b1, 4'h7, 32'hBCBC_1C1C, 1'b1},
    {1'b1, 4'h0, 32'hFFFF_FFFF, 1'b1},
    {1'b0, 4'h0, 32'h1234_5678, 1'b0},
    {1'b1, 4'h0, 32'hDEAD_BEEF, 1'b1}
  };

  always @(negedge sys_clk) begin
    if (mon_en && sys_rst_n && !sys_empty) begin
      got[got_n] = sys_data;
      got_n = got_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic al, input logic [3:0] k, input logic [31:0] d);
    @(negedge lnk_clk);
    lnk_aligned = al; lnk_kflag = k; lnk_data = d;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [35:0] exp_q [16];
    int exp_n = 0;
    int bad = 0;
    int first_bad = -1;

    lnk_rst_n = 1'b0; sys_rst_n = 1'b0;
    repeat (4) @(negedge lnk_clk);
    lnk_rst_n = 1'b1; sys_rst_n = 1'b1;
    repeat (6) @(negedge lnk_clk);

    // R5 reset state
    check(sys_empty == 1'b1, "R5", "empty after reset", sys_empty, 1);
    check(lnk_half == 1'b0, "R6", "half after reset", lnk_half, 0);
    check(lnk_hold == 1'b0, "R7", "hold after reset", lnk_hold, 0);

    // Table walk: R1 R2 R3 R4
    mon_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][37], VEC[i][36:33], VEC[i][32:1]);
      if (VEC[i][0]) begin
        exp_q[exp_n] = {VEC[i][36:33], VEC[i][32:1]};
        exp_n++;
      end
    end
    drive(1'b0, 4'hF, 32'hBCBC_1C1C);
    repeat (30) @(negedge sys_clk);
    check(got_n == exp_n, "R1", "stored word count (R1 R2 R3)", got_n, exp_n);
    for (int i = 0; i < exp_n; i++)
      check(got[i] === exp_q[i], "R4", "ordered word (R2)", got[i], exp_q[i]);
    check(sys_empty == 1'b1, "R5", "empty after drain", sys_empty, 1);
    check(lnk_hold == 1'b0, "R7", "hold low with few words", lnk_hold, 0);

    // Fill with the reader held in reset: R6 R7 R8
    mon_en = 1'b0;
    @(negedge lnk_clk);
    lnk_rst_n = 1'b0; sys_rst_n = 1'b0;
    repeat (3) @(negedge lnk_clk);
    lnk_rst_n = 1'b1;
    repeat (4) @(negedge lnk_clk);
    got_n = 0;
    for (int i = 0; i < 716; i++) drive(1'b1, 4'h0, 32'h1000_0000 + i);
    drive(1'b0, 4'h0, 32'h0);
    check(lnk_half == 1'b0, "R6", "half at 716 words", lnk_half, 0);
    check(lnk_hold == 1'b0, "R7", "hold at 716 words", lnk_hold, 0);
    drive(1'b1, 4'h0, 32'h1000_0000 + 716);
    drive(1'b0, 4'h0, 32'h0);
    check(lnk_half == 1'b1, "R6", "half at 717 words", lnk_half, 1);
    check(lnk_hold == 1'b1, "R7", "hold at 717 words", lnk_hold, 1);
    for (int i = 717; i < 1117; i++) drive(1'b1, 4'h0, 32'h1000_0000 + i);
    drive(1'b0, 4'h0, 32'h0);
    check(lnk_hold == 1'b1, "R7", "hold while full", lnk_hold, 1);

    // Drain: R8 R4 R5 R9
    mon_en = 1'b1;
    sys_rst_n = 1'b1;
    repeat (1200) @(negedge sys_clk);
    check(got_n == 1024, "R8", "words kept when overfilled", got_n, 1024);
    for (int i = 0; i < 1024; i++) begin
      if (got[i] !== {4'h0, 32'h1000_0000 + i}) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    check(bad == 0, "R8", "contents after overfill (R4)",
          (first_bad < 0) ? 64'd0 : 64'(got[first_bad]),
          (first_bad < 0) ? 64'd0 : {28'd0, 4'h0, 32'h1000_0000 + first_bad});
    check(sys_empty == 1'b1, "R5", "empty after full drain", sys_empty, 1);
    repeat (4) @(negedge lnk_clk);
    check(lnk_half == 1'b0, "R9", "half after drain", lnk_half, 0);
    check(lnk_hold == 1'b0, "R9", "hold after drain (R7)", lnk_hold, 0);

    finish_run();
  end
endmodule